// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reset requests of a small microcontroller core into one registered, active-high system reset. Two of the requests are supply levels: a power-on detect and a brown-out detect. The third is an external active-high reset pin, which is synchronised and filtered. The fourth is a single-cycle watchdog trip. A supply level asserts reset at once. Its reset is released only after a per-source delay counter has run out. The external pin has to stay high for a minimum number of samples before it counts. The watchdog trip is stretched into a pulse of fixed length.

While reset is held, the block drives the port output enables to high impedance. In the first cycle after release it gives a one-cycle strobe that loads the program counter with the reset vector. Sticky cause flags record which sources requested reset. Software clears each flag by writing a one to it. Only the power-on level can set the cold-start flag.

Top module: `rstseq_top`

## Requirements
- R1: While `arst_ni` is low, `sys_rst_o` and `port_hiz_o` are 1, `pc_load_o` is 0 and `cause_o` is 0. `sys_rst_o` is the registered OR of all qualified sources.
- R2: `port_hiz_o` equals `sys_rst_o` in every cycle.
- R3: When `por_lvl_i` is sampled high, `sys_rst_o` is 1 in the next cycle. If the level is high for H samples and then low, reset lasts H + POR_DELAY cycles in total.
- R4: If the power-on level returns while its release delay is counting, the count starts again from zero. Reset then lasts for all the high and low samples plus one full POR_DELAY.
- R5: The brown-out level behaves in the same way with its own BOD_DELAY. A pulse of H samples gives a reset of H + BOD_DELAY cycles.
- R6: `ext_pin_i` passes through two flip-flops. A high pulse of fewer than EXT_MIN samples causes no reset and does not set cause bit 2.
- R7: An external pulse of P >= EXT_MIN samples gives a reset of P + 1 - EXT_MIN cycles, starting 3 + EXT_MIN cycles after the first high sample.
- R8: Cause bit 0 (cold start) is set only when `por_lvl_i` is high. Other sources leave it unchanged.
- R9: `pc_load_o` is high for exactly the first cycle after `sys_rst_o` falls. `pc_vec_o` carries RESET_VEC (0 by default).
- R10: A one-cycle `wdt_trip_i` gives a reset that starts two cycles later and lasts WDT_LEN cycles.
- R11: Cause bit 1 is brown-out, bit 2 is external and bit 3 is watchdog. A one on `cause_clr_i[n]` clears bit n. A set in the same cycle wins over the clear. System resets do not clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset of the sequencer itself |
| por_lvl_i | input | 1 | High while the supply is below the power-on threshold |
| bod_lvl_i | input | 1 | High while the supply is below the brown-out trigger |
| ext_pin_i | input | 1 | External active-high reset pin, asynchronous |
| wdt_trip_i | input | 1 | One-cycle watchdog time-out strike |
| cause_clr_i | input | 4 | Write-one-to-clear strobes for the cause flags |
| sys_rst_o | output | 1 | Registered active-high system reset |
| port_hiz_o | output | 1 | Port output enables forced to high impedance |
| pc_load_o | output | 1 | One-cycle program counter load strobe after release |
| pc_vec_o | output | VEC_W | Reset vector value for the program counter |
| cause_o | output | 4 | Sticky reset cause flags |

## Verification
The hardest case to reach is a power-on level that returns while its release counter is part-way through. Seen from the ports, this looks like one long reset, and it shows the restart only through its exact length. The stimulus raises the level, drops it for fewer cycles than the delay, raises it again briefly and then lets it go. A scoreboard entry holds the summed length, and the measured episode must match it to the cycle. The set/clear collision on a cause flag is produced by driving the watchdog trip and the matching clear strobe in the same cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int NSRC = 4;

  typedef enum int unsigned {
    SRC_POR = 0,
    SRC_BOD = 1,
    SRC_EXT = 2,
    SRC_WDT = 3
  } src_e;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/rstseq_supply_hold.sv
module rstseq_supply_hold #(
  parameter int DELAY = 4096
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic lvl_i,
  output logic req_o
);
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DELAY - 1);

  logic          held_q, held_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    held_d = held_q;
    cnt_d  = cnt_q;
    if (lvl_i) begin
      held_d = 1'b1;
      cnt_d  = '0;
    end else if (held_q) begin
      if (cnt_q == CNT_LAST) begin
        held_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      held_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      held_q <= held_d;
      cnt_q  <= cnt_d;
    end
  end

  // immediate assertion path: the level itself requests reset
  assign req_o = lvl_i | held_q;
endmodule

// File: rtl/rstseq_ext_qual.sv
module rstseq_ext_qual #(
  parameter int MIN_HOLD = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic pin_i,
  output logic qual_o
);
  localparam int RW = $clog2(MIN_HOLD + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(MIN_HOLD - 1);

  logic          sync1_q, sync2_q;
  logic [RW-1:0] run_q, run_d;
  logic          qual_q, qual_d;

  always_comb begin
    run_d  = run_q;
    qual_d = qual_q;
    if (!sync2_q) begin
      run_d  = '0;
      qual_d = 1'b0;
    end else if (run_q == RUN_LAST) begin
      qual_d = 1'b1;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      run_q   <= '0;
      qual_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      run_q   <= run_d;
      qual_q  <= qual_d;
    end
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/rstseq_pulse_stretch.sv
module rstseq_pulse_stretch #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic trip_i,
  output logic active_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (trip_i) begin
      cnt_d = CNT_FULL;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int          POR_DELAY = 4096,
  parameter int          BOD_DELAY = 4096,
  parameter int          EXT_MIN   = 2,
  parameter int          WDT_LEN   = 16,
  parameter int          VEC_W     = 16,
  parameter logic [15:0] RESET_VEC = 16'h0000
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             por_lvl_i,
  input  logic             bod_lvl_i,
  input  logic             ext_pin_i,
  input  logic             wdt_trip_i,
  input  logic [3:0]       cause_clr_i,
  output logic             sys_rst_o,
  output logic             port_hiz_o,
  output logic             pc_load_o,
  output logic [VEC_W-1:0] pc_vec_o,
  output logic [3:0]       cause_o
);
  localparam int NSUP = 2;

  logic [NSUP-1:0] sup_lvl;
  logic [NSUP-1:0] sup_req;
  logic            ext_qual;
  logic            wdt_act;

  assign sup_lvl = {bod_lvl_i, por_lvl_i};

  for (genvar g = 0; g < NSUP; g++) begin : g_supply
    localparam int DLY = (g == 0) ? POR_DELAY : BOD_DELAY;
    rstseq_supply_hold #(.DELAY(DLY)) u_hold (
      .clk_i   (clk_i),
      .arst_ni (arst_ni),
      .lvl_i   (sup_lvl[g]),
      .req_o   (sup_req[g])
    );
  end

  rstseq_ext_qual #(.MIN_HOLD(EXT_MIN)) u_ext (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .pin_i   (ext_pin_i),
    .qual_o  (ext_qual)
  );

  rstseq_pulse_stretch #(.LEN(WDT_LEN)) u_wdt (
    .clk_i    (clk_i),
    .arst_ni  (arst_ni),
    .trip_i   (wdt_trip_i),
    .active_o (wdt_act)
  );

  logic     rst_q, rst_d;
  logic     load_q, load_d;
  src_vec_t cause_q, cause_d;
  src_vec_t cause_set;

  always_comb begin
    cause_set          = '0;
    cause_set[SRC_POR] = por_lvl_i;
    cause_set[SRC_BOD] = bod_lvl_i;
    cause_set[SRC_EXT] = ext_qual;
    cause_set[SRC_WDT] = wdt_trip_i;

    rst_d   = (|sup_req) | ext_qual | wdt_act;
    load_d  = rst_q & ~rst_d;
    cause_d = (cause_q & ~cause_clr_i) | cause_set;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      rst_q   <= 1'b1;
      load_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      rst_q   <= rst_d;
      load_q  <= load_d;
      cause_q <= cause_d;
    end
  end

  assign sys_rst_o  = rst_q;
  assign port_hiz_o = rst_q;
  assign pc_load_o  = load_q;
  assign pc_vec_o   = VEC_W'(RESET_VEC);
  assign cause_o    = cause_q;
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
  input logic       clk_i,
  input logic       arst_ni,
  input logic       por_lvl_i,
  input logic       bod_lvl_i,
  input logic       wdt_trip_i,
  input logic [3:0] cause_clr_i,
  input logic       sys_rst_o,
  input logic       pc_load_o,
  input logic [3:0] cause_o
);
  // R3
  a_r3_por_immediate: assert property (@(posedge clk_i) disable iff (!arst_ni)
    por_lvl_i |=> sys_rst_o);

  // R5
  a_r5_bod_immediate: assert property (@(posedge clk_i) disable iff (!arst_ni)
    bod_lvl_i |=> sys_rst_o);

  // R10
  a_r10_wdt_start: assert property (@(posedge clk_i) disable iff (!arst_ni)
    wdt_trip_i |-> ##2 sys_rst_o);

  // R9
  a_r9_load_on_release: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $fell(sys_rst_o) |-> pc_load_o);

  a_r9_load_outside_reset: assert property (@(posedge clk_i) disable iff (!arst_ni)
    pc_load_o |-> !sys_rst_o);

  // R8
  a_r8_cold_by_por_only: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(cause_o[0]) |-> $past(por_lvl_i));

  // R11
  a_r11_wdt_flag_clear: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (cause_clr_i[3] && !wdt_trip_i) |=> !cause_o[3]);
endmodule

bind rstseq_top rstseq_checker u_chk (
  .clk_i       (clk_i),
  .arst_ni     (arst_ni),
  .por_lvl_i   (por_lvl_i),
  .bod_lvl_i   (bod_lvl_i),
  .wdt_trip_i  (wdt_trip_i),
  .cause_clr_i (cause_clr_i),
  .sys_rst_o   (sys_rst_o),
  .pc_load_o   (pc_load_o),
  .cause_o     (cause_o)
);

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;
  localparam int POR_D = 40;
  localparam int BOD_D = 24;
  localparam int EXT_M = 2;
  localparam int WDT_L = 16;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       por_lvl, bod_lvl, ext_pin, wdt_trip;
  logic [3:0] clr;
  logic       sys_rst, port_hiz, pc_load;
  logic [15:0] pc_vec;
  logic [3:0] cause;

  int checks = 0;
  int errors = 0;
  int episodes = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  rstseq_top #(
    .POR_DELAY (POR_D),
    .BOD_DELAY (BOD_D),
    .EXT_MIN   (EXT_M),
    .WDT_LEN   (WDT_L)
  ) dut_i (
    .clk_i       (clk),
    .arst_ni     (arst_n),
    .por_lvl_i   (por_lvl),
    .bod_lvl_i   (bod_lvl),
    .ext_pin_i   (ext_pin),
    .wdt_trip_i  (wdt_trip),
    .cause_clr_i (clr),
    .sys_rst_o   (sys_rst),
    .port_hiz_o  (port_hiz),
    .pc_load_o   (pc_load),
    .pc_vec_o    (pc_vec),
    .cause_o     (cause)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_quiet();
    do @(negedge clk); while (sys_rst);
    cyc(4);
  endtask

  // monitor: measures each reset episode and compares with the scoreboard
  int  run_len = 0;
  bit  hiz_bad = 1'b0;
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (port_hiz != sys_rst) hiz_bad = 1'b1;
      if (sys_rst) begin
        run_len++;
      end else if (run_len > 0) begin
        episodes++;
        if (exp_q.size() == 0) begin
          chk("R1 unexpected reset episode", run_len, 0);
        end else begin
          chk("R3/R5/R7/R10 reset length", run_len, exp_q.pop_front());
        end
        chk("R9 load strobe at release", int'(pc_load), 1);
        chk("R9 reset vector", int'(pc_vec), 0);
        chk("R2 hiz follows reset", int'(hiz_bad), 0);
        hiz_bad = 1'b0;
        run_len = 0;
      end else if (pc_load) begin
        chk("R9 stray load strobe", 1, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ep_before;
    arst_n = 1'b0; por_lvl = 1'b1; bod_lvl = 1'b0; ext_pin = 1'b0;
    wdt_trip = 1'b0; clr = 4'b0;
    cyc(3);
    chk("R1 reset state sys_rst", int'(sys_rst), 1);
    chk("R1 reset state hiz", int'(port_hiz), 1);
    chk("R1 reset state load", int'(pc_load), 0);
    chk("R1 reset state cause", int'(cause), 0);

    // R3: power-on held 5 samples after release
    exp_q.push_back(5 + POR_D);
    arst_n = 1'b1; mon_on = 1'b1;
    cyc(5); por_lvl = 1'b0;
    wait_quiet();
    chk("R8 cold flag set by power-on", int'(cause), 4'b0001);

    // R11: write-one-to-clear of the cold flag
    clr = 4'b0001; cyc(1); clr = 4'b0;
    cyc(1);
    chk("R11 cold flag cleared", int'(cause), 0);

    // R5: brown-out pulse of 3
    exp_q.push_back(3 + BOD_D);
    bod_lvl = 1'b1; cyc(3); bod_lvl = 1'b0;
    wait_quiet();
    chk("R8 brown-out leaves cold flag", int'(cause), 4'b0010);

    // R6: one-sample external pulse is ignored
    ep_before = episodes;
    ext_pin = 1'b1; cyc(1); ext_pin = 1'b0;
    cyc(12);
    chk("R6 short pin pulse no reset", episodes - ep_before, 0);
    chk("R6 short pin pulse no flag", int'(cause[2]), 0);

    // R7: qualifying external pulses
    exp_q.push_back(2 + 1 - EXT_M);
    ext_pin = 1'b1; cyc(2); ext_pin = 1'b0;
    wait_quiet();
    exp_q.push_back(6 + 1 - EXT_M);
    ext_pin = 1'b1; cyc(6); ext_pin = 1'b0;
    wait_quiet();
    chk("R11 external flag set", int'(cause), 4'b0110);

    // R10: watchdog trip
    exp_q.push_back(WDT_L);
    wdt_trip = 1'b1; cyc(1); wdt_trip = 1'b0;
    wait_quiet();
    chk("R11 flags kept across watchdog reset", int'(cause), 4'b1110);
    chk("R8 watchdog leaves cold flag", int'(cause[0]), 0);

    // R4: power-on returns during its countdown
    exp_q.push_back(3 + 10 + 2 + POR_D);
    por_lvl = 1'b1; cyc(3); por_lvl = 1'b0; cyc(10);
    por_lvl = 1'b1; cyc(2); por_lvl = 1'b0;
    wait_quiet();
    chk("R4 cold flag after restart", int'(cause[0]), 1);

    // R11: clear all, then set and clear in the same cycle
    clr = 4'b1111; cyc(1); clr = 4'b0;
    cyc(1);
    chk("R11 clear all flags", int'(cause), 0);
    exp_q.push_back(WDT_L);
    wdt_trip = 1'b1; clr = 4'b1000; cyc(1);
    wdt_trip = 1'b0; clr = 4'b0;
    chk("R11 set wins over clear", int'(cause[3]), 1);
    wait_quiet();
    clr = 4'b1000; cyc(1); clr = 4'b0;
    cyc(1);
    chk("R11 watchdog flag cleared", int'(cause[3]), 0);

    cyc(10);
    chk("R1 all expected episodes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule